// File: doc/BRIEF.md
# SCSI Bus-Master DMA Channel

This block is the bus-master DMA channel of a PCI SCSI adapter. Software sees it as eight 32-bit words plus one control word. It holds the start values for byte count, memory address and descriptor address. A start command copies those values into working copies that the channel then advances. The block decodes four channel operations, keeps six status flags, and drives a single interrupt line. That line merges the SCSI core's interrupt with a DMA-done interrupt that software can enable.

On the data side, the SCSI core offers transfer requests. The channel compares each request's direction with the programmed direction and drops it if they differ. It clamps the length to the bytes still owed and hands one memory access to the bus engine over a valid/ready handshake. In the same cycle it moves the working count down and the working address up. A control-word bit selects how status is cleared: either reading status clears it, or software writes ones to the bits it wants cleared.

Top module: `scsi_dma_chan`

## Requirements
- R1: After reset the command word reads 0, working count 0, working address 0xFFFFFFFF, working descriptor address 0xFFFFFFFD, status 0, and `irq_o`, `dma_en`, `core_cancel` and `mem_valid` are low while `xq_ready` is high.
- R2: Word indices are 0 command, 1 start count, 2 start address, 3 working count, 4 working address, 5 status, 6 start descriptor address, 7 working descriptor address, 8 control. Words 1, 2, 6 and 8 read back what was written, and the command word reads back its low 8 bits.
- R3: A command with bits [1:0]=3 (start) copies word 1 to word 3, word 2 to word 4 and word 6 to word 7. It clears status bits 0 to 5 and raises `dma_en`.
- R4: Command op 0 (idle) lowers `dma_en`. Command op 1 (blast) sets status bit 5. Status bits are 0 power-down, 1 error, 2 abort, 3 done, 4 SCSI interrupt, 5 blast complete.
- R5: Command op 2 (abort) gives `core_cancel` high for exactly the one cycle after the write.
- R6: When control bit 24 is 1, a status write clears bits 1, 2 and 3 where the written value has ones and leaves the other bits alone. A status read does not clear anything.
- R7: When control bit 24 is 0, status writes are ignored. A status read returns the current value, and bits 1, 2 and 3 are cleared afterwards, while bit 4 is kept.
- R8: `irq_o` equals status bit 4 OR (command bit 6 AND status bit 3).
- R9: A rising `core_irq` sets status bit 4. It also sets bit 3 if the command op is start and the working count is 0. A falling `core_irq` clears bit 4.
- R10: A transfer request whose `xq_dir` differs from command bit 7 (1 = device to memory) is accepted and dropped. No memory request is made and the counters do not change.
- R11: A matching request issues length min(`xq_len`, working count) at the current working address. The working count drops by that length and the working address rises by it.
- R12: While `mem_valid` is high and `mem_ready` low, address, length and direction hold steady and `xq_ready` stays low. A cycle with `mem_ready` high ends the request.
- R13: Writes to words 3, 4 and 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (drives clear-on-read) |
| reg_idx | input | 4 | Word index 0..8 |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_idx`, combinational |
| core_irq | input | 1 | Interrupt level from the SCSI core |
| irq_o | output | 1 | Merged interrupt request |
| dma_en | output | 1 | DMA enabled toward the SCSI core |
| core_cancel | output | 1 | One-cycle cancel pulse to the SCSI core |
| xq_valid | input | 1 | Transfer request from the core |
| xq_ready | output | 1 | Channel can take a request |
| xq_dir | input | 1 | Request direction, 1 = device to memory |
| xq_len | input | LEN_W | Requested byte count |
| mem_valid | output | 1 | Memory access request |
| mem_ready | input | 1 | Memory access taken |
| mem_addr | output | DATA_W | Memory access address |
| mem_len | output | LEN_W | Memory access byte count |
| mem_dir | output | 1 | Memory access direction |

## Verification
The bench builds the channel with an 8-bit request length and 32-bit registers. With those values a single request of 200 bytes is larger than a 2-byte remainder, so the clamp path is exercised. A full 255-byte request is also reachable against a larger count. Control bit 24 is kept at its default position, and both clear policies are exercised on the same done flag. A zero start count makes the done-on-interrupt path reachable.

// File: rtl/scsi_dma_pkg.sv
`timescale 1ns/1ps
package scsi_dma_pkg;
   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_BLAST = 2'd1,
      OP_ABORT = 2'd2,
      OP_START = 2'd3
   } dma_op_e;

   localparam logic [3:0] IX_CMD  = 4'd0;
   localparam logic [3:0] IX_SCNT = 4'd1;
   localparam logic [3:0] IX_SADR = 4'd2;
   localparam logic [3:0] IX_WCNT = 4'd3;
   localparam logic [3:0] IX_WADR = 4'd4;
   localparam logic [3:0] IX_STAT = 4'd5;
   localparam logic [3:0] IX_SDSC = 4'd6;
   localparam logic [3:0] IX_WDSC = 4'd7;
   localparam logic [3:0] IX_CTL  = 4'd8;

   localparam int ST_PWDN = 0;
   localparam int ST_ERR  = 1;
   localparam int ST_ABT  = 2;
   localparam int ST_DONE = 3;
   localparam int ST_SINT = 4;
   localparam int ST_BLST = 5;
   localparam int ST_W    = 6;

   localparam int CB_DIE  = 6;
   localparam int CB_DIR  = 7;
   localparam int CMD_W   = 8;

   localparam logic [ST_W-1:0] ST_CLRMASK = 6'b001110;
endpackage

// File: rtl/dma_edge_det.sv
`timescale 1ns/1ps
module dma_edge_det (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   output logic rise_o,
   output logic fall_o
);
   logic prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl_i;
   end

   assign rise_o = lvl_i & ~prev_q;
   assign fall_o = ~lvl_i & prev_q;
endmodule

// File: rtl/dma_xfer_engine.sv
`timescale 1ns/1ps
module dma_xfer_engine #(
   parameter int DATA_W = 32,
   parameter int LEN_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              xq_valid_i,
   input  logic              xq_dir_i,
   input  logic [LEN_W-1:0]  xq_len_i,
   output logic              xq_ready_o,
   input  logic              cmd_dir_i,
   input  logic [DATA_W-1:0] wcnt_i,
   input  logic [DATA_W-1:0] wadr_i,
   output logic              adv_en_o,
   output logic [DATA_W-1:0] adv_len_o,
   output logic              mem_valid_o,
   input  logic              mem_ready_i,
   output logic [DATA_W-1:0] mem_addr_o,
   output logic [LEN_W-1:0]  mem_len_o,
   output logic              mem_dir_o
);
   if (LEN_W < 1 || LEN_W > DATA_W) begin : g_bad_len
      $error("dma_xfer_engine: LEN_W must be in 1..DATA_W");
   end

   logic [DATA_W-1:0] len_ext;
   logic [DATA_W-1:0] take;
   logic              busy_q;
   logic              accept;
   logic              match;

   if (LEN_W == DATA_W) begin : g_len_full
      assign len_ext = xq_len_i;
   end else begin : g_len_pad
      assign len_ext = {{(DATA_W-LEN_W){1'b0}}, xq_len_i};
   end

   assign take       = (len_ext > wcnt_i) ? wcnt_i : len_ext;
   assign xq_ready_o = ~busy_q;
   assign accept     = xq_valid_i & ~busy_q;
   assign match      = (xq_dir_i == cmd_dir_i);
   assign adv_en_o   = accept & match;
   assign adv_len_o  = take;
   assign mem_valid_o = busy_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q     <= 1'b0;
         mem_addr_o <= '0;
         mem_len_o  <= '0;
         mem_dir_o  <= 1'b0;
      end else if (busy_q) begin
         if (mem_ready_i) busy_q <= 1'b0;
      end else if (accept && match) begin
         busy_q     <= 1'b1;
         mem_addr_o <= wadr_i;
         mem_len_o  <= take[LEN_W-1:0];
         mem_dir_o  <= xq_dir_i;
      end
   end

   // R12: request held steady until taken
   assert_mem_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid_o && !mem_ready_i) |=>
         (mem_valid_o && $stable(mem_addr_o) && $stable(mem_len_o) && $stable(mem_dir_o)));

   // R11: issued length never exceeds remaining count
   assert_len_clamp_R11: assert property (@(posedge clk) disable iff (!rst_n)
      adv_en_o |-> (adv_len_o <= wcnt_i && adv_len_o <= len_ext));

   // R10: mismatching direction leaves the memory side idle
   assert_dir_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (xq_valid_i && xq_ready_o && (xq_dir_i != cmd_dir_i)) |=> !mem_valid_o);
endmodule

// File: rtl/dma_chan_regs.sv
`timescale 1ns/1ps
module dma_chan_regs
   import scsi_dma_pkg::*;
#(
   parameter int              DATA_W   = 32,
   parameter int              CLR_BIT  = 24,
   parameter logic [DATA_W-1:0] WADR_RST = '1,
   parameter logic [DATA_W-1:0] WDSC_RST = {{(DATA_W-2){1'b1}}, 2'b01}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic              rd_i,
   input  logic [3:0]        idx_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   input  logic              adv_en_i,
   input  logic [DATA_W-1:0] adv_len_i,
   input  logic              irq_rise_i,
   input  logic              irq_fall_i,
   output logic [DATA_W-1:0] wcnt_o,
   output logic [DATA_W-1:0] wadr_o,
   output logic              cmd_dir_o,
   output logic              irq_o,
   output logic              dma_en_o,
   output logic              cancel_o
);
   if (CLR_BIT < 0 || CLR_BIT >= DATA_W || DATA_W < CMD_W) begin : g_bad_cfg
      $error("dma_chan_regs: CLR_BIT out of range or DATA_W too small");
   end

   logic [CMD_W-1:0]  cmd_q;
   logic [DATA_W-1:0] scnt_q, sadr_q, sdsc_q, wcnt_q, wadr_q, wdsc_q, ctl_q;
   logic [ST_W-1:0]   st_q, st_n;
   logic              cmd_wr, start_go, w1c_mode;
   dma_op_e           op;

   assign op       = dma_op_e'(wdata_i[1:0]);
   assign cmd_wr   = wr_i && (idx_i == IX_CMD);
   assign start_go = cmd_wr && (op == OP_START);
   assign w1c_mode = ctl_q[CLR_BIT];

   // status next-state: command, then core edge, then clearing policy
   always_comb begin
      st_n = st_q;
      if (cmd_wr) begin
         if (op == OP_START)      st_n = '0;
         else if (op == OP_BLAST) st_n[ST_BLST] = 1'b1;
      end
      if (irq_rise_i) begin
         st_n[ST_SINT] = 1'b1;
         if (cmd_q[1:0] == OP_START && wcnt_q == '0) st_n[ST_DONE] = 1'b1;
      end
      if (irq_fall_i) st_n[ST_SINT] = 1'b0;
      if (wr_i && idx_i == IX_STAT && w1c_mode)
         st_n = st_n & ~(wdata_i[ST_W-1:0] & ST_CLRMASK);
      if (rd_i && idx_i == IX_STAT && !w1c_mode)
         st_n = st_n & ~ST_CLRMASK;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q    <= '0;
         scnt_q   <= '0;
         sadr_q   <= '0;
         sdsc_q   <= '0;
         ctl_q    <= '0;
         wcnt_q   <= '0;
         wadr_q   <= WADR_RST;
         wdsc_q   <= WDSC_RST;
         st_q     <= '0;
         dma_en_o <= 1'b0;
         cancel_o <= 1'b0;
      end else begin
         st_q     <= st_n;
         cancel_o <= cmd_wr && (op == OP_ABORT);
         if (cmd_wr) cmd_q <= wdata_i[CMD_W-1:0];
         if (wr_i && idx_i == IX_SCNT) scnt_q <= wdata_i;
         if (wr_i && idx_i == IX_SADR) sadr_q <= wdata_i;
         if (wr_i && idx_i == IX_SDSC) sdsc_q <= wdata_i;
         if (wr_i && idx_i == IX_CTL)  ctl_q  <= wdata_i;
         if (start_go) begin
            wcnt_q   <= scnt_q;
            wadr_q   <= sadr_q;
            wdsc_q   <= sdsc_q;
            dma_en_o <= 1'b1;
         end else begin
            if (adv_en_i) begin
               wcnt_q <= wcnt_q - adv_len_i;
               wadr_q <= wadr_q + adv_len_i;
            end
            if (cmd_wr && op == OP_IDLE) dma_en_o <= 1'b0;
         end
      end
   end

   always_comb begin
      case (idx_i)
         IX_CMD:  rdata_o = {{(DATA_W-CMD_W){1'b0}}, cmd_q};
         IX_SCNT: rdata_o = scnt_q;
         IX_SADR: rdata_o = sadr_q;
         IX_WCNT: rdata_o = wcnt_q;
         IX_WADR: rdata_o = wadr_q;
         IX_STAT: rdata_o = {{(DATA_W-ST_W){1'b0}}, st_q};
         IX_SDSC: rdata_o = sdsc_q;
         IX_WDSC: rdata_o = wdsc_q;
         IX_CTL:  rdata_o = ctl_q;
         default: rdata_o = '0;
      endcase
   end

   assign wcnt_o    = wcnt_q;
   assign wadr_o    = wadr_q;
   assign cmd_dir_o = cmd_q[CB_DIR];
   assign irq_o     = st_q[ST_SINT] | (cmd_q[CB_DIE] & st_q[ST_DONE]);

   // R9: core interrupt edges move the SCSI-interrupt flag
   assert_rise_sint_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_rise_i |=> st_q[ST_SINT]);
   assert_fall_sint_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_fall_i |=> !st_q[ST_SINT]);

   // R3: start loads the working copies
   assert_start_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      start_go |=> (wcnt_q == $past(scnt_q) && wadr_q == $past(sadr_q) && dma_en_o));

   // R11: accepted transfer moves both counters by the same amount
   assert_advance_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_en_i && !start_go) |=>
         (wcnt_q == $past(wcnt_q - adv_len_i) && wadr_q == $past(wadr_q + adv_len_i)));

   // R13: working count is not writable
   assert_wcnt_ro_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && idx_i == IX_WCNT && !adv_en_i && !start_go) |=> $stable(wcnt_q));

   // R5: cancel only follows an abort command
   assert_cancel_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cancel_o |-> $past(wr_i && idx_i == IX_CMD && wdata_i[1:0] == 2'd2));
endmodule

// File: rtl/scsi_dma_chan.sv
`timescale 1ns/1ps
module scsi_dma_chan #(
   parameter int DATA_W  = 32,
   parameter int LEN_W   = 16,
   parameter int CLR_BIT = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [3:0]        reg_idx,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              core_irq,
   output logic              irq_o,
   output logic              dma_en,
   output logic              core_cancel,
   input  logic              xq_valid,
   output logic              xq_ready,
   input  logic              xq_dir,
   input  logic [LEN_W-1:0]  xq_len,
   output logic              mem_valid,
   input  logic              mem_ready,
   output logic [DATA_W-1:0] mem_addr,
   output logic [LEN_W-1:0]  mem_len,
   output logic              mem_dir
);
   logic              irq_rise, irq_fall;
   logic              adv_en, cmd_dir;
   logic [DATA_W-1:0] adv_len, wcnt, wadr;

   dma_edge_det u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  (core_irq),
      .rise_o (irq_rise),
      .fall_o (irq_fall)
   );

   dma_chan_regs #(
      .DATA_W  (DATA_W),
      .CLR_BIT (CLR_BIT)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_i       (reg_wr),
      .rd_i       (reg_rd),
      .idx_i      (reg_idx),
      .wdata_i    (reg_wdata),
      .rdata_o    (reg_rdata),
      .adv_en_i   (adv_en),
      .adv_len_i  (adv_len),
      .irq_rise_i (irq_rise),
      .irq_fall_i (irq_fall),
      .wcnt_o     (wcnt),
      .wadr_o     (wadr),
      .cmd_dir_o  (cmd_dir),
      .irq_o      (irq_o),
      .dma_en_o   (dma_en),
      .cancel_o   (core_cancel)
   );

   dma_xfer_engine #(
      .DATA_W (DATA_W),
      .LEN_W  (LEN_W)
   ) u_xfer (
      .clk         (clk),
      .rst_n       (rst_n),
      .xq_valid_i  (xq_valid),
      .xq_dir_i    (xq_dir),
      .xq_len_i    (xq_len),
      .xq_ready_o  (xq_ready),
      .cmd_dir_i   (cmd_dir),
      .wcnt_i      (wcnt),
      .wadr_i      (wadr),
      .adv_en_o    (adv_en),
      .adv_len_o   (adv_len),
      .mem_valid_o (mem_valid),
      .mem_ready_i (mem_ready),
      .mem_addr_o  (mem_addr),
      .mem_len_o   (mem_len),
      .mem_dir_o   (mem_dir)
   );

   // R12: no new request offered while one is outstanding
   assert_busy_block_R12: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid |-> !xq_ready);
endmodule

// File: tb/sim_scsi_dma_chan.sv
`timescale 1ns/1ps
module sim_scsi_dma_chan;
   localparam int DW = 32;
   localparam int LW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0, reg_rd = 1'b0;
   logic [3:0]    reg_idx = '0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic          core_irq = 1'b0;
   logic          irq_o, dma_en, core_cancel;
   logic          xq_valid = 1'b0, xq_ready, xq_dir = 1'b0;
   logic [LW-1:0] xq_len = '0;
   logic          mem_valid, mem_ready = 1'b0, mem_dir;
   logic [DW-1:0] mem_addr;
   logic [LW-1:0] mem_len;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   scsi_dma_chan #(.DATA_W(DW), .LEN_W(LW), .CLR_BIT(24)) u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .core_irq(core_irq), .irq_o(irq_o), .dma_en(dma_en),
      .core_cancel(core_cancel), .xq_valid(xq_valid), .xq_ready(xq_ready),
      .xq_dir(xq_dir), .xq_len(xq_len), .mem_valid(mem_valid),
      .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_len(mem_len),
      .mem_dir(mem_dir)
   );

   task automatic check(string req, string what, logic [DW-1:0] got, logic [DW-1:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
      end
   endtask

   task automatic wr(logic [3:0] idx, logic [DW-1:0] val);
      @(negedge clk);
      reg_wr = 1'b1; reg_idx = idx; reg_wdata = val;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic peek(logic [3:0] idx, output logic [DW-1:0] v);
      reg_idx = idx;
      #0.5;
      v = reg_rdata;
   endtask

   task automatic rd(logic [3:0] idx, output logic [DW-1:0] v);
      @(negedge clk);
      reg_rd = 1'b1; reg_idx = idx;
      #0.5;
      v = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic core_edge(logic lvl);
      @(negedge clk);
      core_irq = lvl;
      @(negedge clk);
   endtask

   task automatic t_reset;
      logic [DW-1:0] v;
      peek(4'd0, v); check("R1", "cmd", v, 32'h0);
      peek(4'd3, v); check("R1", "wcnt", v, 32'h0);
      peek(4'd4, v); check("R1", "wadr", v, 32'hFFFF_FFFF);
      peek(4'd7, v); check("R1", "wdsc", v, 32'hFFFF_FFFD);
      peek(4'd5, v); check("R1", "stat", v, 32'h0);
      check("R1", "irq/en/cancel/mvalid/ready",
            {27'd0, irq_o, dma_en, core_cancel, mem_valid, xq_ready}, 32'h1);
   endtask

   task automatic t_regs;
      logic [DW-1:0] v;
      wr(4'd1, 32'h10); wr(4'd2, 32'h1000); wr(4'd6, 32'hABCD0);
      peek(4'd1, v); check("R2", "scnt", v, 32'h10);
      peek(4'd2, v); check("R2", "sadr", v, 32'h1000);
      peek(4'd6, v); check("R2", "sdsc", v, 32'hABCD0);
   endtask

   task automatic t_blast_start_idle;
      logic [DW-1:0] v;
      wr(4'd0, 32'h1);
      peek(4'd5, v); check("R4", "blast sets bit5", v, 32'h20);
      wr(4'd0, 32'h3);
      peek(4'd0, v); check("R2", "cmd readback", v, 32'h3);
      peek(4'd3, v); check("R3", "wcnt loaded", v, 32'h10);
      peek(4'd4, v); check("R3", "wadr loaded", v, 32'h1000);
      peek(4'd7, v); check("R3", "wdsc loaded", v, 32'hABCD0);
      peek(4'd5, v); check("R3", "stat cleared", v, 32'h0);
      check("R3", "dma_en", {31'd0, dma_en}, 32'h1);
      wr(4'd0, 32'h0);
      check("R4", "idle drops dma_en", {31'd0, dma_en}, 32'h0);
   endtask

   task automatic t_abort;
      check("R5", "cancel before", {31'd0, core_cancel}, 32'h0);
      wr(4'd0, 32'h2);
      check("R5", "cancel pulse", {31'd0, core_cancel}, 32'h1);
      @(negedge clk);
      check("R5", "cancel ends", {31'd0, core_cancel}, 32'h0);
   endtask

   task automatic t_irq;
      logic [DW-1:0] v;
      wr(4'd1, 32'h0); wr(4'd0, 32'h43);
      core_edge(1'b1);
      peek(4'd5, v); check("R9", "rise with zero count", v, 32'h18);
      check("R8", "irq high", {31'd0, irq_o}, 32'h1);
      core_edge(1'b0);
      peek(4'd5, v); check("R9", "fall clears bit4", v, 32'h08);
      check("R8", "irq from done+enable", {31'd0, irq_o}, 32'h1);
      wr(4'd1, 32'h5); wr(4'd0, 32'h3);
      core_edge(1'b1);
      peek(4'd5, v); check("R9", "rise, count nonzero", v, 32'h10);
      check("R8", "irq from sint", {31'd0, irq_o}, 32'h1);
      core_edge(1'b0);
      check("R8", "irq low", {31'd0, irq_o}, 32'h0);
      wr(4'd1, 32'h0); wr(4'd0, 32'h3);
      core_edge(1'b1); core_edge(1'b0);
      peek(4'd5, v); check("R9", "done without enable", v, 32'h08);
      check("R8", "done masked", {31'd0, irq_o}, 32'h0);
   endtask

   task automatic t_cor;
      logic [DW-1:0] v;
      wr(4'd5, 32'h3F);
      peek(4'd5, v); check("R7", "write ignored", v, 32'h08);
      rd(4'd5, v); check("R7", "read returns old", v, 32'h08);
      peek(4'd5, v); check("R7", "cleared after read", v, 32'h0);
      wr(4'd0, 32'h3);
      core_edge(1'b1);
      rd(4'd5, v); check("R7", "read with sint", v, 32'h18);
      peek(4'd5, v); check("R7", "sint kept", v, 32'h10);
      core_edge(1'b0);
   endtask

   task automatic t_w1c;
      logic [DW-1:0] v;
      wr(4'd8, 32'h0100_0000);
      peek(4'd8, v); check("R2", "ctl readback", v, 32'h0100_0000);
      wr(4'd0, 32'h3);
      core_edge(1'b1); core_edge(1'b0);
      rd(4'd5, v); check("R6", "read value", v, 32'h08);
      peek(4'd5, v); check("R6", "read does not clear", v, 32'h08);
      wr(4'd5, 32'h30);
      peek(4'd5, v); check("R6", "non-clearable ones", v, 32'h08);
      wr(4'd5, 32'h08);
      peek(4'd5, v); check("R6", "done cleared", v, 32'h0);
      wr(4'd8, 32'h0);
   endtask

   task automatic offer(logic dir, logic [LW-1:0] len);
      @(negedge clk);
      xq_valid = 1'b1; xq_dir = dir; xq_len = len;
      @(negedge clk);
      xq_valid = 1'b0;
   endtask

   task automatic finish_mem;
      @(negedge clk); mem_ready = 1'b1;
      @(negedge clk); mem_ready = 1'b0;
      check("R12", "ended", {30'd0, mem_valid, xq_ready}, 32'h1);
   endtask

   task automatic t_xfer;
      logic [DW-1:0] v;
      wr(4'd1, 32'h5); wr(4'd2, 32'h2000); wr(4'd0, 32'h3);
      offer(1'b1, 8'd3);
      check("R10", "dropped, no request", {31'd0, mem_valid}, 32'h0);
      peek(4'd3, v); check("R10", "wcnt unchanged", v, 32'h5);
      peek(4'd4, v); check("R10", "wadr unchanged", v, 32'h2000);
      offer(1'b0, 8'd3);
      check("R11", "request", {mem_valid, mem_dir, 22'd0, mem_len}, {1'b1, 1'b0, 22'd0, 8'd3});
      check("R11", "addr", mem_addr, 32'h2000);
      peek(4'd3, v); check("R11", "wcnt down", v, 32'h2);
      peek(4'd4, v); check("R11", "wadr up", v, 32'h2003);
      @(negedge clk); @(negedge clk);
      check("R12", "held", {mem_valid, xq_ready, 22'd0, mem_len}, {1'b1, 1'b0, 22'd0, 8'd3});
      check("R12", "addr held", mem_addr, 32'h2000);
      finish_mem;
      offer(1'b0, 8'd200);
      check("R11", "clamped len", {24'd0, mem_len}, 32'd2);
      check("R11", "clamped addr", mem_addr, 32'h2003);
      peek(4'd3, v); check("R11", "wcnt zero", v, 32'h0);
      peek(4'd4, v); check("R11", "wadr end", v, 32'h2005);
      finish_mem;
      wr(4'd1, 32'h100); wr(4'd2, 32'h40); wr(4'd0, 32'h83);
      offer(1'b1, 8'hFF);
      check("R11", "dev-to-mem req", {mem_valid, mem_dir, 22'd0, mem_len}, {1'b1, 1'b1, 22'd0, 8'hFF});
      check("R11", "dev-to-mem addr", mem_addr, 32'h40);
      peek(4'd3, v); check("R11", "wcnt rem", v, 32'h1);
      peek(4'd4, v); check("R11", "wadr rem", v, 32'h13F);
      finish_mem;
   endtask

   task automatic t_ro;
      logic [DW-1:0] v;
      wr(4'd3, 32'h55); wr(4'd4, 32'h66); wr(4'd7, 32'h77);
      peek(4'd3, v); check("R13", "wcnt kept", v, 32'h1);
      peek(4'd4, v); check("R13", "wadr kept", v, 32'h13F);
      peek(4'd7, v); check("R13", "wdsc kept", v, 32'hABCD0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_regs;
      t_blast_start_idle;
      t_abort;
      t_irq;
      t_cor;
      t_w1c;
      t_xfer;
      t_ro;
      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule